// File: doc/BRIEF.md
# Quarter-Cycle Mains Interference Averager

This block removes periodic mains hum from a stream of conversions taken on several multiplexed channels. An upstream sequencer converts every channel once in each quarter of the mains cycle. At 50 Hz one full scan of the channels takes 5 ms, and at 60 Hz it takes about 4.167 ms. Every channel is always scanned, so the quarter spacing is kept. For each channel the block keeps the four most recent samples, which are one quarter cycle apart. It reports their sum. Hum components sampled half a cycle apart have equal size and opposite sign, so they cancel in the sum.

Each accepted sample replaces the oldest stored sample of its channel. The sum for that channel is then presented for one cycle. A channel's result is marked valid only once that channel holds four samples, which means four complete scans after a flush. A result can be read as the full sum, or as the mean (the sum shifted right by two). A clear input empties all storage. Changing the mains mode input does the same, because samples spaced for one mains frequency are meaningless for the other.

Top module: `lnr_quad_avg`

## Requirements
- R1: While reset is low, and in the first cycle after it, `out_valid` is 0 and `full` is all zeros.
- R2: Each channel has a two-bit write position that starts at slot 0, advances by one per accepted sample and wraps from 3 to 0. The fifth sample of a channel therefore replaces its first sample.
- R3: With `mean_sel` = 0, `out_data` is the exact two's-complement sum of the channel's four stored signed samples. It is two bits wider than `in_data`, so four samples of +32767 give +131068 with no overflow.
- R4: `out_valid` goes high in the cycle after an accepted sample (`in_valid` = 1 with no flush) only if that channel then holds four samples. `out_ch` then equals the `in_ch` of that sample.
- R5: `full[c]` is 1 exactly when channel c holds four samples. Once set, it stays set until a flush.
- R6: With `mean_sel` = 1, `out_data` is the four-sample sum arithmetically shifted right by 2, which rounds toward minus infinity. A sum of -923 gives -231, and a sum of -2 gives -1.
- R7: `clear` = 1 zeroes every slot, every write position and every fill count. A sample offered in the same cycle is discarded, and `out_valid` is 0 in the next cycle.
- R8: A change of `mode_60hz` between two cycles flushes the block exactly as `clear` does.
- R9: Channels are independent. A sample for one channel changes neither the stored samples nor the fill state of any other channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| clear | input | 1 | Flush all channels |
| mode_60hz | input | 1 | Mains mode: 0 for 50 Hz, 1 for 60 Hz; a change flushes |
| mean_sel | input | 1 | 1 selects the mean, 0 selects the four-sample sum |
| in_valid | input | 1 | Sample strobe |
| in_ch | input | 3 | Channel index of the sample |
| in_data | input | 16 | Signed sample word |
| out_valid | output | 1 | Filtered result valid |
| out_ch | output | 3 | Channel of the filtered result |
| out_data | output | 18 | Signed filtered result |
| full | output | 8 | Per-channel flag: four samples held |

## Verification
Two channels are interleaved with hand-picked values. These values separate a correct oldest-slot replacement from writing the wrong slot. They also separate a true sign-extended sum from a truncated one, and a floor shift from a rounding or unsigned shift. The extremes +32767 and -32768 expose a sum kept at sample width. Full scans over all eight channels, with values that encode both the channel and the scan number, show that results stay invalid until the fourth scan and that channels do not leak into each other. A fifth scan shows the wrap of the write position. A clear raised together with a sample, and a toggle of the mains mode, show that both flushes drop the pending sample and restart filling.

// File: rtl/lnr_pkg.sv
package lnr_pkg;
    // Default geometry of the averager
    localparam int DEF_SAMPLE_W  = 16;
    localparam int DEF_NUM_CH    = 8;
    localparam int DEF_NUM_SLOTS = 4;
endpackage

// File: rtl/lnr_lane.sv
// One channel: circular slot store, running sum and fill count.
module lnr_lane #(
    parameter int SAMPLE_W  = 16,
    parameter int NUM_SLOTS = 4,
    localparam int PTR_W    = $clog2(NUM_SLOTS),
    localparam int CNT_W    = $clog2(NUM_SLOTS + 1),
    localparam int SUM_W    = SAMPLE_W + PTR_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                flush,
    input  logic                wr_en,
    input  logic [SAMPLE_W-1:0] wr_data,
    output logic [SUM_W-1:0]    sum_nx,
    output logic                full_nx,
    output logic                full_q
);
    localparam int EXT_W = SUM_W - SAMPLE_W;

    typedef struct packed {
        logic [NUM_SLOTS-1:0][SAMPLE_W-1:0] slot;
        logic [SUM_W-1:0]                   sum;
        logic [PTR_W-1:0]                   ptr;
        logic [CNT_W-1:0]                   cnt;
    } lane_t;

    lane_t lane_d, lane_q;
    logic [SAMPLE_W-1:0] oldest;
    logic [SUM_W-1:0]    old_x, new_x;

    always_comb begin
        lane_d = lane_q;
        oldest = lane_q.slot[lane_q.ptr];
        old_x  = {{EXT_W{oldest[SAMPLE_W-1]}}, oldest};
        new_x  = {{EXT_W{wr_data[SAMPLE_W-1]}}, wr_data};
        if (flush) begin
            lane_d = '0;
        end else if (wr_en) begin
            lane_d.slot[lane_q.ptr] = wr_data;
            lane_d.sum = lane_q.sum - old_x + new_x;
            lane_d.ptr = PTR_W'(lane_q.ptr + 1'b1);
            if (lane_q.cnt != CNT_W'(NUM_SLOTS)) begin
                lane_d.cnt = CNT_W'(lane_q.cnt + 1'b1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lane_q <= '0;
        end else begin
            lane_q <= lane_d;
        end
    end

    assign sum_nx  = lane_d.sum;
    assign full_nx = (lane_d.cnt == CNT_W'(NUM_SLOTS));
    assign full_q  = (lane_q.cnt == CNT_W'(NUM_SLOTS));
endmodule

// File: rtl/lnr_out_stage.sv
// Result register: sum or mean, channel tag and strobe.
module lnr_out_stage #(
    parameter int SUM_W = 18,
    parameter int CH_W  = 3,
    parameter int SHIFT = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take,
    input  logic [CH_W-1:0]  take_ch,
    input  logic [SUM_W-1:0] take_sum,
    input  logic             mean_sel,
    output logic             res_valid,
    output logic [CH_W-1:0]  res_ch,
    output logic [SUM_W-1:0] res_data
);
    typedef struct packed {
        logic             valid;
        logic [CH_W-1:0]  ch;
        logic [SUM_W-1:0] data;
    } res_t;

    res_t res_d, res_q;

    always_comb begin
        res_d       = res_q;
        res_d.valid = take;
        if (take) begin
            res_d.ch   = take_ch;
            res_d.data = mean_sel ? SUM_W'($signed(take_sum) >>> SHIFT) : take_sum;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign res_valid = res_q.valid;
    assign res_ch    = res_q.ch;
    assign res_data  = res_q.data;
endmodule

// File: rtl/lnr_quad_avg.sv
module lnr_quad_avg #(
    parameter int SAMPLE_W  = lnr_pkg::DEF_SAMPLE_W,
    parameter int NUM_CH    = lnr_pkg::DEF_NUM_CH,
    parameter int NUM_SLOTS = lnr_pkg::DEF_NUM_SLOTS,
    localparam int CH_W     = $clog2(NUM_CH),
    localparam int PTR_W    = $clog2(NUM_SLOTS),
    localparam int SUM_W    = SAMPLE_W + PTR_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clear,
    input  logic                mode_60hz,
    input  logic                mean_sel,
    input  logic                in_valid,
    input  logic [CH_W-1:0]     in_ch,
    input  logic [SAMPLE_W-1:0] in_data,
    output logic                out_valid,
    output logic [CH_W-1:0]     out_ch,
    output logic [SUM_W-1:0]    out_data,
    output logic [NUM_CH-1:0]   full
);
    typedef struct packed {
        logic mode;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic                          flush;
    logic                          ch_ok;
    logic [NUM_CH-1:0]             wr_en;
    logic [NUM_CH-1:0]             full_nx;
    logic [NUM_CH-1:0][SUM_W-1:0]  sum_nx;
    logic                          take;
    logic [SUM_W-1:0]              take_sum;

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.mode = mode_60hz;
        flush      = clear || (mode_60hz != ctl_q.mode);
        ch_ok      = (32'(in_ch) < NUM_CH);
        take       = 1'b0;
        take_sum   = '0;
        if (in_valid && ch_ok && !flush) begin
            take     = full_nx[in_ch];
            take_sum = sum_nx[in_ch];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q.mode <= mode_60hz;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_lane
        assign wr_en[c] = in_valid && (in_ch == CH_W'(c));
        lnr_lane #(
            .SAMPLE_W (SAMPLE_W),
            .NUM_SLOTS(NUM_SLOTS)
        ) u_lane (
            .clk    (clk),
            .rst_n  (rst_n),
            .flush  (flush),
            .wr_en  (wr_en[c]),
            .wr_data(in_data),
            .sum_nx (sum_nx[c]),
            .full_nx(full_nx[c]),
            .full_q (full[c])
        );
    end

    lnr_out_stage #(
        .SUM_W(SUM_W),
        .CH_W (CH_W),
        .SHIFT(PTR_W)
    ) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .take     (take),
        .take_ch  (in_ch),
        .take_sum (take_sum),
        .mean_sel (mean_sel),
        .res_valid(out_valid),
        .res_ch   (out_ch),
        .res_data (out_data)
    );
endmodule

// File: rtl/lnr_quad_avg_chk.sv
module lnr_quad_avg_chk #(
    parameter int NUM_CH = 8,
    parameter int CH_W   = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              clear,
    input logic              mode_60hz,
    input logic              in_valid,
    input logic [CH_W-1:0]   in_ch,
    input logic              out_valid,
    input logic [CH_W-1:0]   out_ch,
    input logic [NUM_CH-1:0] full
);
    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && full == '0)); // R1

    AST_VALID_FROM_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid)); // R4

    AST_VALID_CHANNEL: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_ch == $past(in_ch))); // R4

    AST_VALID_NEEDS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> full[out_ch]); // R5

    AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && $stable(mode_60hz)) |=> ((full & $past(full)) == $past(full))); // R5

    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (full == '0 && !out_valid)); // R7

    AST_MODE_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mode_60hz) |=> (full == '0 && !out_valid)); // R8
endmodule

bind lnr_quad_avg lnr_quad_avg_chk #(
    .NUM_CH(NUM_CH),
    .CH_W  (CH_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (clear),
    .mode_60hz(mode_60hz),
    .in_valid (in_valid),
    .in_ch    (in_ch),
    .out_valid(out_valid),
    .out_ch   (out_ch),
    .full     (full)
);

// File: tb/lnr_quad_avg_test.sv
`timescale 1ns/1ps
module lnr_quad_avg_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clear = 1'b0;
    logic        mode_60hz = 1'b0;
    logic        mean_sel = 1'b0;
    logic        in_valid = 1'b0;
    logic [2:0]  in_ch = '0;
    logic [15:0] in_data = '0;
    logic        out_valid;
    logic [2:0]  out_ch;
    logic [17:0] out_data;
    logic [7:0]  full;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    lnr_quad_avg uut (
        .clk(clk), .rst_n(rst_n), .clear(clear), .mode_60hz(mode_60hz),
        .mean_sel(mean_sel), .in_valid(in_valid), .in_ch(in_ch), .in_data(in_data),
        .out_valid(out_valid), .out_ch(out_ch), .out_data(out_data), .full(full)
    );

    // Vector table: channel, sample, mean select, expected valid, expected result
    localparam int NV = 12;
    localparam int V_CH   [NV] = '{3, 5, 3, 5, 3, 5, 3, 5, 3, 5, 3, 5};
    localparam int V_DAT  [NV] = '{100, 32767, -40, 32767, 7, 32767, 20, 32767,
                                   50, -32768, -1000, -32768};
    localparam int V_MEAN [NV] = '{0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 1};
    localparam int V_VAL  [NV] = '{0, 0, 0, 0, 0, 0, 1, 1, 1, 1, 1, 1};
    localparam int V_EXP  [NV] = '{0, 0, 0, 0, 0, 0, 87, 131068, 37, 65533, -231, -1};

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Drive one sample; return at the following falling edge, when the result is visible
    task automatic send(input int ch, input int dat, input int mean);
        @(negedge clk);
        in_valid = 1'b1;
        in_ch    = 3'(ch);
        in_data  = 16'(dat);
        mean_sel = mean[0];
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    function automatic int sres();
        return int'($signed(out_data));
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 valid in reset", longint'(out_valid), 0);
        check("R1 full in reset", longint'(full), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 valid after reset", longint'(out_valid), 0);
        check("R1 full after reset", longint'(full), 0);

        // Table walk: R2 replacement, R3 sum, R4 valid, R6 mean
        for (int i = 0; i < NV; i++) begin
            send(V_CH[i], V_DAT[i], V_MEAN[i]);
            check($sformatf("R4 valid vec%0d", i), longint'(out_valid), V_VAL[i]);
            if (V_VAL[i] != 0) begin
                check($sformatf("R4 ch vec%0d", i), longint'(out_ch), V_CH[i]);
                if (V_MEAN[i] != 0)
                    check($sformatf("R6 mean vec%0d", i), sres(), V_EXP[i]);
                else if (i < 8)
                    check($sformatf("R3 sum vec%0d", i), sres(), V_EXP[i]);
                else
                    check($sformatf("R2 replace vec%0d", i), sres(), V_EXP[i]);
            end
        end
        check("R5 R9 full after table", longint'(full), 8'h28);

        // Clear together with a sample: everything flushed, sample dropped
        @(negedge clk);
        clear = 1'b1; in_valid = 1'b1; in_ch = 3'd3; in_data = 16'd999;
        @(negedge clk);
        clear = 1'b0; in_valid = 1'b0;
        check("R7 valid after clear", longint'(out_valid), 0);
        check("R7 full after clear", longint'(full), 0);
        send(3, 1, 0); send(3, 2, 0); send(3, 3, 0);
        check("R7 no valid on third sample", longint'(out_valid), 0);
        check("R5 not full after three", longint'(full[3]), 0);
        send(3, 4, 0);
        check("R7 valid on fourth sample", longint'(out_valid), 1);
        check("R7 sum from fresh slots", sres(), 10);
        check("R5 full after four", longint'(full), 8'h08);

        // Full scans over all channels
        @(negedge clk); clear = 1'b1; @(negedge clk); clear = 1'b0;
        for (int s = 0; s < 4; s++) begin
            for (int c = 0; c < 8; c++) begin
                send(c, c * 10 + s, 0);
                check($sformatf("R4 scan%0d ch%0d valid", s, c), longint'(out_valid), (s == 3) ? 1 : 0);
                if (s == 3) begin
                    check($sformatf("R9 scan ch%0d sum", c), sres(), c * 40 + 6);
                    check($sformatf("R4 scan ch%0d tag", c), longint'(out_ch), c);
                end
            end
            if (s == 2) check("R5 no channel full before fourth scan", longint'(full), 0);
        end
        check("R5 all full", longint'(full), 8'hFF);
        for (int c = 0; c < 8; c++) begin
            send(c, c * 10 + 4, 0);
            check($sformatf("R2 wrap ch%0d sum", c), sres(), c * 40 + 10);
        end

        // Mains mode change flushes
        @(negedge clk); mode_60hz = 1'b1; in_valid = 1'b1; in_ch = 3'd0; in_data = 16'd500;
        @(negedge clk); in_valid = 1'b0;
        check("R8 full after mode change", longint'(full), 0);
        check("R8 valid after mode change", longint'(out_valid), 0);
        send(0, 1, 0); send(0, 1, 0); send(0, 1, 0);
        check("R8 refill needs four", longint'(out_valid), 0);
        send(0, 1, 0);
        check("R8 refill sum", sres(), 4);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule